// File: doc/BRIEF.md
# Security Code Validation Controller

This block decides whether a presented security code matches the code held in memory, and from that whether access is granted for the current session. The presenter opens a presentation with a start strobe and sends the code one bit per cycle with a valid qualifier. It then closes the presentation with an end strobe. The stored code comes from the memory array, which lies outside the block, as a parallel word. Each bit that arrives is compared at once against the matching stored bit. A sticky mismatch latch gathers the result, and the decision is taken when the end strobe arrives.

A correct presentation sets the session flag and clears the run of wrong presentations. A wrong presentation clears the session flag and adds one to the attempt count. When the count reaches four, the controller locks for good. From then on every presentation is rejected and the session flag can no longer be set. A supply-drop input clears the session flag and abandons any presentation in progress. It leaves the attempt count alone, because that count stands for a non-volatile field. The access mode output chooses between the personalization rules and the issued-card rules. It follows from the second fuse and from the level on the fuse pad. Under the personalization rules the code guards the whole memory. Under the issued rules it guards only the application zones.

Top module: `sec_code_guard`

## Requirements
- R1: After reset, `sessionOk` is 0, `attemptCnt` is 0 and `locked` is 0.
- R2: The first bit taken after `cmpStart` is compared with `storedCode[0]`, the next with `storedCode[1]`, and so on. If exactly 16 bits all match, `sessionOk` reads 1 after the clock edge that samples `cmpEnd`.
- R3: A presentation in which any bit differs from the stored bit is wrong. After its `cmpEnd` edge, `sessionOk` is 0 and `attemptCnt` has risen by one. This also holds when a session was open before.
- R4: A presentation with fewer or more than 16 valid bits is wrong, even when every bit it sends matches.
- R5: A correct presentation on an unlocked controller sets `attemptCnt` back to 0.
- R6: `attemptCnt` saturates at 4. `locked` is 1 exactly when the count is 4, and it stays 1 until reset.
- R7: While `locked` is 1, a presentation of the correct code leaves `sessionOk` at 0 and `attemptCnt` at 4.
- R8: A cycle with `pwrFail` high clears `sessionOk` at that edge and keeps `attemptCnt`. Bits taken before it are discarded, so a presentation that is not restarted with `cmpStart` is judged on the bits that follow only.
- R9: `persoMode` is 1 exactly when `padHigh` is 1 and `fuse2Blown` is 0. It is combinational. A value of 1 selects the personalization rules (the code guards all memory); 0 selects the issued rules (the code guards the application zones only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low initialisation |
| pwrFail | input | 1 | Supply-drop indication; clears the session |
| cmpStart | input | 1 | Opens a presentation |
| cmpValid | input | 1 | Qualifies `cmpBit` |
| cmpBit | input | 1 | Serial code bit, code bit 0 first |
| cmpEnd | input | 1 | Closes a presentation and triggers the decision |
| storedCode | input | 16 | Code word read from the array |
| fuse2Blown | input | 1 | Personalization fuse state, 1 = blown |
| padHigh | input | 1 | Fuse pad supply present |
| sessionOk | output | 1 | Access granted for this session |
| locked | output | 1 | Permanent invalidation |
| attemptCnt | output | 3 | Consecutive wrong presentations |
| persoMode | output | 1 | 1 = personalization rules, 0 = issued rules |

## Verification
Each presentation kind listed here is sent against the same stored code:
- The exact code, which tells the grant path apart from all the others.
- Single-bit flips at the low, middle and top positions, which show that the mismatch latch catches every position.
- The code sent in reverse order, which shows that bit 0 is compared first.
- 15-bit and 17-bit sends of matching bits, which show that the decision checks the bit count as well as the bit values.
- A supply drop in the middle of a presentation, which separates discarding the earlier bits from keeping them.
- A run of wrong presentations followed by the correct code, which shows that the lock rejects a match and that the count saturates.

// File: rtl/sec_code_guard_pkg.sv
package sec_code_guard_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrCmp;   // abandon/restart the comparison
    logic takeBit;  // compare the current serial bit
    logic judge;    // decision cycle; comparison state is cleared after it
  } cmpStrobe_t;
endpackage

// File: rtl/scg_datapath.sv
module scg_datapath
  import sec_code_guard_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpStrobe_t        strb,
  input  logic              cmpBit,
  input  logic [CODE_W-1:0] storedCode,
  output logic              codeMatch
);
  localparam int IDX_W = $clog2(CODE_W + 2);
  localparam int SEL_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IDX_W-1:0] FULL = IDX_W'(CODE_W);
  localparam logic [IDX_W-1:0] OVER = IDX_W'(CODE_W + 1);

  logic [IDX_W-1:0] bitIdx;
  logic             mismatch;
  logic             expBit;

  // Stored bit expected at the current position (only used while bitIdx < FULL)
  assign expBit = storedCode[bitIdx[SEL_W-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx   <= '0;
      mismatch <= 1'b0;
    end else if (strb.clrCmp || strb.judge) begin
      bitIdx   <= '0;
      mismatch <= 1'b0;
    end else if (strb.takeBit) begin
      if (bitIdx >= FULL) mismatch <= 1'b1;        // too many bits
      else if (cmpBit != expBit) mismatch <= 1'b1;
      if (bitIdx != OVER) bitIdx <= bitIdx + 1'b1;  // saturate past the end
    end
  end

  assign codeMatch = !mismatch && (bitIdx == FULL);
endmodule

// File: rtl/scg_control.sv
module scg_control
  import sec_code_guard_pkg::*;
#(
  parameter int MAX_FAILS = 4,
  parameter int CNT_W     = $clog2(MAX_FAILS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrFail,
  input  logic             cmpStart,
  input  logic             cmpValid,
  input  logic             cmpEnd,
  input  logic             codeMatch,
  output cmpStrobe_t       strb,
  output logic             sessionOk,
  output logic             locked,
  output logic [CNT_W-1:0] attemptCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_FAILS);

  logic judge;
  logic grant;

  assign judge = cmpEnd && !pwrFail;
  assign grant = judge && codeMatch && !locked;

  always_comb begin
    strb.clrCmp  = cmpStart || pwrFail;
    strb.judge   = judge;
    strb.takeBit = cmpValid && !cmpStart && !cmpEnd && !pwrFail;
  end

  assign locked = (attemptCnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sessionOk <= 1'b0;
    end else if (pwrFail) begin
      sessionOk <= 1'b0;
    end else if (judge) begin
      sessionOk <= grant;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attemptCnt <= '0;
    end else if (judge && !locked) begin
      if (codeMatch) attemptCnt <= '0;
      else           attemptCnt <= attemptCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sec_code_guard.sv
module sec_code_guard
  import sec_code_guard_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int MAX_FAILS = 4,
  parameter int CNT_W     = $clog2(MAX_FAILS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrFail,
  input  logic              cmpStart,
  input  logic              cmpValid,
  input  logic              cmpBit,
  input  logic              cmpEnd,
  input  logic [CODE_W-1:0] storedCode,
  input  logic              fuse2Blown,
  input  logic              padHigh,
  output logic              sessionOk,
  output logic              locked,
  output logic [CNT_W-1:0]  attemptCnt,
  output logic              persoMode
);
  cmpStrobe_t strb;
  logic       codeMatch;

  scg_control #(.MAX_FAILS(MAX_FAILS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrFail(pwrFail),
    .cmpStart(cmpStart), .cmpValid(cmpValid), .cmpEnd(cmpEnd),
    .codeMatch(codeMatch), .strb(strb),
    .sessionOk(sessionOk), .locked(locked), .attemptCnt(attemptCnt)
  );

  scg_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpBit(cmpBit),
    .storedCode(storedCode), .codeMatch(codeMatch)
  );

  // Personalization rules only with the pad powered and the fuse intact
  assign persoMode = padHigh && !fuse2Blown;
endmodule

// File: rtl/scg_checker.sv
module scg_checker #(
  parameter int MAX_FAILS = 4,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrFail,
  input logic             sessionOk,
  input logic             locked,
  input logic [CNT_W-1:0] attemptCnt
);
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rstN)
    attemptCnt <= CNT_W'(MAX_FAILS));

  a_r7_no_session_locked: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !sessionOk);

  a_r8_pwrfail_clears: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> !sessionOk);

  a_r8_pwrfail_keeps_cnt: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> attemptCnt == $past(attemptCnt));

  a_r5_grant_clears_cnt: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sessionOk) |-> attemptCnt == '0);

  a_r3_cnt_steps: assert property (@(posedge clk) disable iff (!rstN)
    (attemptCnt != $past(attemptCnt)) |->
      (attemptCnt == $past(attemptCnt) + CNT_W'(1) || attemptCnt == '0));
endmodule

bind sec_code_guard scg_checker #(.MAX_FAILS(MAX_FAILS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .pwrFail(pwrFail), .sessionOk(sessionOk),
  .locked(locked), .attemptCnt(attemptCnt)
);

// File: tb/tb_sec_code_guard.sv
`timescale 1ns/1ps
module tb_sec_code_guard;
  localparam logic [15:0] CODE = 16'h1F35;

  logic clk = 1'b0, rstN = 1'b0, pwrFail = 1'b0;
  logic cmpStart = 1'b0, cmpValid = 1'b0, cmpBit = 1'b0, cmpEnd = 1'b0;
  logic [15:0] storedCode = CODE;
  logic fuse2Blown = 1'b0, padHigh = 1'b0;
  logic sessionOk, locked, persoMode;
  logic [2:0] attemptCnt;
  int nChk = 0, nFail = 0;

  always #5 clk = ~clk;

  sec_code_guard dut (
    .clk(clk), .rstN(rstN), .pwrFail(pwrFail), .cmpStart(cmpStart),
    .cmpValid(cmpValid), .cmpBit(cmpBit), .cmpEnd(cmpEnd),
    .storedCode(storedCode), .fuse2Blown(fuse2Blown), .padHigh(padHigh),
    .sessionOk(sessionOk), .locked(locked), .attemptCnt(attemptCnt),
    .persoMode(persoMode)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [15:0] val, input int n);
    for (int i = 0; i < n; i++) begin
      cmpValid = 1'b1;
      cmpBit   = (i < 16) ? val[i] : 1'b0;
      @(negedge clk);
    end
    cmpValid = 1'b0;
  endtask

  // Full presentation; outputs are sampled one negedge after the end strobe
  task automatic present(input logic [15:0] val, input int n);
    cmpStart = 1'b1; @(negedge clk); cmpStart = 1'b0;
    sendBits(val, n);
    cmpEnd = 1'b1; @(negedge clk); cmpEnd = 1'b0;
  endtask

  function automatic logic [15:0] reverse16(input logic [15:0] v);
    for (int i = 0; i < 16; i++) reverse16[i] = v[15-i];
  endfunction

  task automatic t_reset();
    check("R1 session", sessionOk, 0);
    check("R1 count", attemptCnt, 0);
    check("R1 lock", locked, 0);
  endtask

  task automatic t_match();
    present(CODE, 16);
    check("R2 session after match", sessionOk, 1);
    check("R2 count after match", attemptCnt, 0);
    present(reverse16(CODE), 16);
    check("R2 reversed order rejected", sessionOk, 0);
    check("R3 count after reversed", attemptCnt, 1);
  endtask

  task automatic t_flip();
    present(CODE, 16);
    check("R5 count cleared", attemptCnt, 0);
    check("R2 session reopened", sessionOk, 1);
    present(CODE ^ 16'h0001, 16);
    check("R3 flip bit0 session", sessionOk, 0);
    check("R3 flip bit0 count", attemptCnt, 1);
    present(CODE ^ 16'h0100, 16);
    check("R3 flip bit8 count", attemptCnt, 2);
    present(CODE ^ 16'h8000, 16);
    check("R3 flip bit15 count", attemptCnt, 3);
    present(CODE, 16);
    check("R5 count cleared after 3", attemptCnt, 0);
  endtask

  task automatic t_length();
    present(CODE, 15);
    check("R4 short session", sessionOk, 0);
    check("R4 short count", attemptCnt, 1);
    present(CODE, 16);
    present(CODE, 17);
    check("R4 long session", sessionOk, 0);
    check("R4 long count", attemptCnt, 1);
  endtask

  task automatic t_power();
    present(CODE, 16);
    check("R2 session before drop", sessionOk, 1);
    present(CODE ^ 16'h0010, 16);
    present(CODE, 16);            // count back to 0, session open
    pwrFail = 1'b1; @(negedge clk); pwrFail = 1'b0;
    check("R8 session cleared", sessionOk, 0);
    check("R8 count kept", attemptCnt, 0);
    // Wrong once, then a drop must keep count 1
    present(CODE ^ 16'h0004, 16);
    pwrFail = 1'b1; @(negedge clk); pwrFail = 1'b0;
    check("R8 count kept at 1", attemptCnt, 1);
    // Drop mid-presentation discards the first half
    cmpStart = 1'b1; @(negedge clk); cmpStart = 1'b0;
    sendBits(CODE, 8);
    pwrFail = 1'b1; @(negedge clk); pwrFail = 1'b0;
    sendBits(CODE >> 8, 8);
    cmpEnd = 1'b1; @(negedge clk); cmpEnd = 1'b0;
    check("R8 aborted presentation session", sessionOk, 0);
    check("R8 aborted presentation count", attemptCnt, 2);
    present(CODE, 16);
    check("R5 recovered", attemptCnt, 0);
  endtask

  task automatic t_mode();
    for (int m = 0; m < 4; m++) begin
      padHigh = m[0]; fuse2Blown = m[1];
      #1;
      check("R9 mode", persoMode, (m == 1) ? 1 : 0);
    end
    padHigh = 1'b0; fuse2Blown = 1'b0;
  endtask

  task automatic t_lock();
    for (int k = 1; k <= 4; k++) begin
      present(CODE ^ 16'h0200, 16);
      check("R6 count climbs", attemptCnt, k);
      check("R6 lock state", locked, (k == 4) ? 1 : 0);
    end
    present(CODE ^ 16'h0200, 16);
    check("R6 count saturates", attemptCnt, 4);
    present(CODE, 16);
    check("R7 match rejected when locked", sessionOk, 0);
    check("R7 count held", attemptCnt, 4);
    check("R6 lock sticky", locked, 1);
    pwrFail = 1'b1; @(negedge clk); pwrFail = 1'b0;
    check("R6 lock survives drop", locked, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_flip();
    t_length();
    t_power();
    t_mode();
    t_lock();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #1000000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule